// File: doc/BRIEF.md
# Bus Cycle READY Wait Controller

This block runs the command phase of an external bus access. A start request taken in idle drops either the read strobe or the write strobe, both active low. The strobe then stays low for a programmed number of fixed wait states. After those, the cycle either ends at once or waits until an external READY line is seen active. The cycle ends by raising the strobe and pulsing a one-clock completion flag. Address phases, latch-enable timing, chip-select decoding and data steering belong to other blocks.

READY can be taken in two ways. In synchronous mode the pin is sampled directly on the bus clock, so the peripheral must meet setup and hold. In asynchronous mode the pin goes through a two-flop chain. This costs one more wait state, and the raw pin is captured one clock before the point where it would be sampled in synchronous mode. READY is never used to end a cycle while the programmed wait states are still running. This protects against peripherals that hold READY active while idle and only pull it inactive some time after the strobe falls.

Top module: `cmd_wait_seq`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `rd_n_o` and `wr_n_o` are 1 and `done_o` is 0.
- R2: A high `start_i` at a clock edge in idle drops exactly one strobe for the next clock: `rd_n_o` when `is_write_i`=0, `wr_n_o` when `is_write_i`=1. The two strobes are never low together. A strobe, once low, stays low until the clock in which `done_o` is 1.
- R3: With `rdy_en_i`=0, a wait field value N keeps the strobe low for exactly N+1 clocks, whatever `rdy_pin_i` does.
- R4: With `rdy_en_i`=1 and `rdy_async_i`=0, the pin is first examined at the edge that ends the (N+1)th low clock. If the pin is 1 there, the strobe rises at that edge.
- R5: With READY enabled, each examination that finds READY inactive adds exactly one more low clock. The cycle ends at the first examination that finds it active.
- R6: With `rdy_en_i`=1 and `rdy_async_i`=1, the first examination comes at the edge ending low clock N+2. Each examination at edge k after the start edge uses the pin value taken at edge k-2.
- R7: The synchronizer chain is cleared when a cycle starts, so a pin value held from before the start (or at the start edge) cannot end an asynchronous cycle. With N=0 and the pin held at 1 throughout, the strobe stays low for 3 clocks.
- R8: `done_o` is 1 for exactly one clock, in the same clock that the strobe first reads back 1. After that, `rdy_pin_i` has no effect until the next start.
- R9: `start_i` is ignored while a cycle is in progress. A request in that time changes neither the strobe in use nor the cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Cycle request, taken only in idle |
| is_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| ws_cnt_i | input | WS_W (4) | Wait field N; N+1 fixed wait states |
| rdy_en_i | input | 1 | 1 = cycle end also needs READY |
| rdy_async_i | input | 1 | 1 = READY passes through the synchronizer |
| rdy_pin_i | input | 1 | Raw READY line, active high |
| rd_n_o | output | 1 | Read strobe, active low, registered |
| wr_n_o | output | 1 | Write strobe, active low, registered |
| done_o | output | 1 | One-clock cycle completion pulse |

## Verification
The bench targets a normally-ready peripheral that drops READY only after the strobe falls. A controller that looked at READY during the fixed wait states would end that cycle early and come out short. It also runs asynchronous cycles with a late READY and with READY held high from before the start. An off-by-one in the synchronizer depth, or a chain that keeps stale state, would change the low length by one clock or end a zero-wait asynchronous cycle after two clocks. READY toggling after the strobe rises, and a start pulse in the middle of a cycle, would expose a controller that lets either of them restart or stretch a cycle.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIXED  = 2'd1,
    PH_EXTEND = 2'd2
  } phase_t;
endpackage

// File: rtl/cmdw_wait_counter.sv
module cmdw_wait_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cmdw_ready_sync.sv
module cmdw_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift,
  input  logic async_sel,
  input  logic pin,
  output logic ready
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst || clear)  chain_q <= '0;
        else if (shift)    chain_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst || clear)  chain_q <= '0;
        else if (shift)    chain_q <= {chain_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign ready = async_sel ? chain_q[STAGES-1] : pin;
endmodule

// File: rtl/cmdw_strobe_reg.sv
module cmdw_strobe_reg (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic set_write,
  input  logic clr,
  output logic rd_n,
  output logic wr_n
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_n <= 1'b1;
      wr_n <= 1'b1;
    end else if (set) begin
      rd_n <= set_write;
      wr_n <= ~set_write;
    end
  end
endmodule

// File: rtl/cmd_wait_seq.sv
module cmd_wait_seq
  import cmdw_pkg::*;
#(
  parameter int WS_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            is_write_i,
  input  logic [WS_W-1:0] ws_cnt_i,
  input  logic            rdy_en_i,
  input  logic            rdy_async_i,
  input  logic            rdy_pin_i,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output logic            done_o
);
  localparam int CNT_W = WS_W + 1;

  phase_t     phase_q;
  logic       en_q, async_q, done_q;
  logic       take, cnt_zero, sync_rdy, decide, ok, finish;
  logic [CNT_W-1:0] load_val;

  assign take     = (phase_q == PH_IDLE) && start_i;
  assign load_val = {1'b0, ws_cnt_i} + CNT_W'(rdy_en_i & rdy_async_i);
  assign decide   = ((phase_q == PH_FIXED) && cnt_zero) || (phase_q == PH_EXTEND);
  assign ok       = ~en_q | sync_rdy;
  assign finish   = decide && ok;

  cmdw_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (take),
    .load_val (load_val),
    .run      (phase_q == PH_FIXED),
    .zero     (cnt_zero)
  );

  cmdw_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .clear     (take),
    .shift     (phase_q != PH_IDLE),
    .async_sel (async_q),
    .pin       (rdy_pin_i),
    .ready     (sync_rdy)
  );

  cmdw_strobe_reg u_strb (
    .clk       (clk),
    .rst       (rst),
    .set       (take),
    .set_write (is_write_i),
    .clr       (finish),
    .rd_n      (rd_n_o),
    .wr_n      (wr_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      en_q    <= 1'b0;
      async_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (phase_q)
        PH_IDLE: if (take) begin
          phase_q <= PH_FIXED;
          en_q    <= rdy_en_i;
          async_q <= rdy_async_i;
        end
        PH_FIXED: if (cnt_zero) phase_q <= ok ? PH_IDLE : PH_EXTEND;
        PH_EXTEND: if (ok) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/cmd_wait_seq_chk.sv
module cmd_wait_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic done_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (rd_n_o && wr_n_o && !done_o));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n_o && !wr_n_o));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst) !rd_n_o |=> (!rd_n_o || done_o));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst) !wr_n_o |=> (!wr_n_o || done_o));

  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n_o) || $fell(wr_n_o)) |-> $past(start_i));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rd_n_o && wr_n_o && $past(!rd_n_o || !wr_n_o)));
endmodule

bind cmd_wait_seq cmd_wait_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .rd_n_o  (rd_n_o),
  .wr_n_o  (wr_n_o),
  .done_o  (done_o)
);

// File: tb/sim_cmd_wait_seq.sv
`timescale 1ns/1ps
module sim_cmd_wait_seq;
  localparam int WS_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, is_write_i = 1'b0, rdy_en_i = 1'b0, rdy_async_i = 1'b0, rdy_pin_i = 1'b0;
  logic [WS_W-1:0] ws_cnt_i = '0;
  logic rd_n_o, wr_n_o, done_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  cmd_wait_seq #(.WS_W(WS_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
    .ws_cnt_i(ws_cnt_i), .rdy_en_i(rdy_en_i), .rdy_async_i(rdy_async_i),
    .rdy_pin_i(rdy_pin_i), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .done_o(done_o)
  );

  // behavioural reference
  bit m_busy = 0, m_rd = 1, m_wr = 1, m_done = 0;
  bit m_en, m_asy;
  int m_k, m_n;
  bit hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_rd = 1; m_wr = 1; m_done = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy = 1; m_k = 0; m_n = ws_cnt_i; m_en = rdy_en_i; m_asy = rdy_async_i;
          hist.delete(); hist.push_back(1'b0);
          if (is_write_i) m_wr = 0; else m_rd = 0;
        end
      end else begin
        bit ok;
        int fixed;
        m_k++;
        hist.push_back(rdy_pin_i);
        fixed = m_n + 1 + ((m_en && m_asy) ? 1 : 0);
        if (m_k >= fixed) begin
          if (!m_en) ok = 1;
          else if (!m_asy) ok = rdy_pin_i;
          else ok = (m_k - 2 >= 1) ? hist[m_k-2] : 1'b0;
          if (ok) begin m_busy = 0; m_done = 1; m_rd = 1; m_wr = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if ({rd_n_o, wr_n_o, done_o} !== {m_rd, m_wr, m_done}) begin
        fails++;
        $display("FAIL %s: per-clock rd_n/wr_n/done actual=%b%b%b expected=%b%b%b",
                 cur_req, rd_n_o, wr_n_o, done_o, m_rd, m_wr, m_done);
      end
    end
  end

  function automatic bit pin_at(int i, int rise, int lo, int hi);
    return (i >= rise) && !(i >= lo && i <= hi);
  endfunction

  task automatic run_cycle(input bit wr, input int n, input bit en, input bit asy,
                           input int rise, input int lo, input int hi,
                           input int exp_len, input int mid_start, input string tag);
    int len = 0;
    cur_req = tag;
    @(negedge clk);
    start_i = 1; is_write_i = wr; ws_cnt_i = n[WS_W-1:0]; rdy_en_i = en; rdy_async_i = asy;
    rdy_pin_i = pin_at(0, rise, lo, hi);
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (wr ? !wr_n_o : !rd_n_o) len++;
      if (done_o) break;
      start_i = (i == mid_start);
      if (i == mid_start) is_write_i = ~wr;
      rdy_pin_i = pin_at(i, rise, lo, hi);
    end
    start_i = 0;
    checks++;
    if (len != exp_len) begin
      fails++;
      $display("FAIL %s: strobe low clocks actual=%0d expected=%0d", tag, len, exp_len);
    end
    // READY activity after the cycle must leave the outputs idle
    for (int j = 0; j < 4; j++) begin
      rdy_pin_i = ~rdy_pin_i;
      @(negedge clk);
      checks++;
      if (!(rd_n_o && wr_n_o && !done_o)) begin
        fails++;
        $display("FAIL R8: idle after cycle actual=%b%b%b expected=110", rd_n_o, wr_n_o, done_o);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (!(rd_n_o && wr_n_o && !done_o)) begin
      fails++;
      $display("FAIL R1: reset state actual=%b%b%b expected=110", rd_n_o, wr_n_o, done_o);
    end
    rst = 0;
    // R3: READY off, pin toggling ignored, N=2 -> 3 clocks
    run_cycle(0, 2, 0, 0, 0, 1, 1, 3, -1, "R3");
    // R4: sync, READY already active, N=2 -> 3 clocks
    run_cycle(0, 2, 1, 0, 0, 0, -1, 3, -1, "R4");
    // R5: sync, READY active from edge 6, N=1 -> 6 clocks
    run_cycle(1, 1, 1, 0, 6, 0, -1, 6, -1, "R5");
    // R6: async, READY from edge 1, N=2 -> 4 clocks
    run_cycle(0, 2, 1, 1, 1, 0, -1, 4, -1, "R6");
    // R6: async, READY from edge 5, N=1 -> 7 clocks
    run_cycle(1, 1, 1, 1, 5, 0, -1, 7, -1, "R6");
    // R7: async, READY held high from before start, N=0 -> 3 clocks
    run_cycle(0, 0, 1, 1, 0, 0, -1, 3, -1, "R7");
    // R5: normally-ready peripheral, low on edges 1..3, N=3 -> 4 clocks
    run_cycle(1, 3, 1, 0, 0, 1, 3, 4, -1, "R5");
    // R4: normally-ready too slow, low edges 1..5, N=3 -> 6 clocks
    run_cycle(0, 3, 1, 0, 0, 1, 5, 6, -1, "R4");
    // R9: start pulse mid-cycle with the other direction
    run_cycle(0, 4, 0, 0, 0, 0, -1, 5, 2, "R9");
    // R2: write strobe with zero wait field
    run_cycle(1, 0, 0, 0, 0, 0, -1, 1, -1, "R2");
    // R8: async, done pulse then READY activity
    run_cycle(1, 2, 1, 1, 2, 0, -1, 4, -1, "R8");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule